// File: doc/BRIEF.md
# Interrupt Eligibility Bank

This block keeps the per-line state of a bank of interrupt lines and works out, each clock, which lines may be offered to the processor. Each line has six state bits: a pending latch, an enable bit, an active bit, a trigger type (edge or level), a group bit and a group-modifier bit. The block also samples the raw input level of every line. A line counts as pending when its latch is set, or when it is level-triggered and its sampled input is high. It is eligible when it is pending, enabled and not active, and when its group class is switched on by the control flags.

Single-cycle write strobes set or clear the pending, enable and active bits. A configuration strobe loads the trigger type, group and modifier of all lines in one cycle. Four control flags select which classes pass: a secure-off flag, a group 0 enable, a secure group 1 enable and a non-secure group 1 enable. When secure-off is set, every modifier bit reads as zero. Priority selection and routing are done by logic outside this block, which reads the registered eligible vector and the any-eligible flag.

Top module: `irq_elig_bank`

## Requirements
- R1: In reset, `eligible` and `any_eligible` are 0. Reset clears pending, enable, active, group and modifier state, and makes every line level-triggered (trigger bit 0).
- R2: A line is pending when its pending latch is 1, or when its trigger bit is 0 and its sampled input is 1. A level line whose input returns low stops being pending.
- R3: For a line with trigger bit 1, a 0-to-1 change of `line_in` between two consecutive clock samples sets its pending latch at that edge. An input held high does not set the latch again after it has been cleared.
- R4: `pend_set`/`pend_clr`, `en_set`/`en_clr` and `act_set`/`act_clr` are per-line write-1 strobes that take effect at the clock edge. When set and clear are both asserted for a line, clear wins, including over an edge event in the same cycle.
- R5: A pending line is eligible only while its enable bit is 1 and its active bit is 0.
- R6: While `ctl_sec_off` is 1, every modifier bit is treated as 0.
- R7: A line with group bit 1 passes only while `ctl_en_g1ns` is 1.
- R8: A line with group bit 0 and effective modifier 1 passes only while `ctl_en_g1s` is 1.
- R9: A line with group bit 0 and effective modifier 0 passes only while `ctl_en_g0` is 1.
- R10: `eligible` is a register. At each edge it takes the value computed from the state held just before that edge and the control flags present at it. A strobe or input change therefore appears two edges later, and a control flag change one edge later.
- R11: `any_eligible` equals the OR of all bits of `eligible`, in the same cycle.
- R12: A `cfg_we` pulse loads `cfg_edge` (1 = edge-triggered), `cfg_grp` and `cfg_gmod` for all lines at once. An edge event in that same cycle is judged by the trigger type held before the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_in | input | NLINES | Raw interrupt input levels |
| pend_set | input | NLINES | Write-1 strobe that sets the pending latch |
| pend_clr | input | NLINES | Write-1 strobe that clears the pending latch |
| en_set | input | NLINES | Write-1 strobe that sets the enable bit |
| en_clr | input | NLINES | Write-1 strobe that clears the enable bit |
| act_set | input | NLINES | Write-1 strobe that sets the active bit |
| act_clr | input | NLINES | Write-1 strobe that clears the active bit |
| cfg_we | input | 1 | Loads trigger type, group and modifier for all lines |
| cfg_edge | input | NLINES | Trigger type to load, 1 = edge |
| cfg_grp | input | NLINES | Group bits to load |
| cfg_gmod | input | NLINES | Modifier bits to load |
| ctl_sec_off | input | 1 | Secure-off flag; forces modifiers to 0 |
| ctl_en_g0 | input | 1 | Group 0 enable |
| ctl_en_g1s | input | 1 | Secure group 1 enable |
| ctl_en_g1ns | input | 1 | Non-secure group 1 enable |
| eligible | output | NLINES | Registered vector of lines that may be signalled |
| any_eligible | output | 1 | 1 when any bit of `eligible` is 1 |

## Verification
A level line is driven high and then low with no strobe, which shows that level pending follows the live input. An edge line's input is held high across a clear, which shows that edge pending is latched only on a transition. Lines of all three group classes are kept pending together while the sixteen control-flag combinations are swept, so a wrong class decode or a missing modifier fold changes exactly one bit. Simultaneous set and clear strobes, and enable or active toggling, separate the priority and gating rules. A long stretch of random inputs is then compared every cycle against a per-line behavioural model, which exposes any off-by-one in the register timing.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  // Distributor-level control flags that gate the group classes
  typedef struct packed {
    logic sec_off;   // modifiers read as zero
    logic en_g0;     // group 0
    logic en_g1s;    // secure group 1
    logic en_g1ns;   // non-secure group 1
  } irq_ctl_t;

endpackage

// File: rtl/irq_line_sampler.sv
module irq_line_sampler #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] line_in,
  output logic [NLINES-1:0] lvl_q,
  output logic [NLINES-1:0] rise_w
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= line_in;
  end

  // transition between the previous sample and the current input
  assign rise_w = line_in & ~lvl_q;

endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] rise,
  input  logic [NLINES-1:0] pend_set,
  input  logic [NLINES-1:0] pend_clr,
  input  logic [NLINES-1:0] en_set,
  input  logic [NLINES-1:0] en_clr,
  input  logic [NLINES-1:0] act_set,
  input  logic [NLINES-1:0] act_clr,
  input  logic              cfg_we,
  input  logic [NLINES-1:0] cfg_edge,
  input  logic [NLINES-1:0] cfg_grp,
  input  logic [NLINES-1:0] cfg_gmod,
  output logic [NLINES-1:0] pend_q,
  output logic [NLINES-1:0] en_q,
  output logic [NLINES-1:0] act_q,
  output logic [NLINES-1:0] edge_q,
  output logic [NLINES-1:0] grp_q,
  output logic [NLINES-1:0] gmod_q
);

  // set/clear update with clear taking priority
  function automatic logic [NLINES-1:0] sc_next(input logic [NLINES-1:0] cur,
                                                input logic [NLINES-1:0] s,
                                                input logic [NLINES-1:0] c);
    return (cur | s) & ~c;
  endfunction

  // edge event only on lines currently configured as edge-triggered
  logic [NLINES-1:0] edge_hit_w;
  assign edge_hit_w = rise & edge_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      act_q  <= '0;
      edge_q <= '0;
      grp_q  <= '0;
      gmod_q <= '0;
    end else begin
      pend_q <= sc_next(pend_q, pend_set | edge_hit_w, pend_clr);
      en_q   <= sc_next(en_q, en_set, en_clr);
      act_q  <= sc_next(act_q, act_set, act_clr);
      if (cfg_we) begin
        edge_q <= cfg_edge;
        grp_q  <= cfg_grp;
        gmod_q <= cfg_gmod;
      end
    end
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((pend_q & $past(pend_clr)) == '0)); // R4
  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (($past(edge_hit_w & ~pend_clr) & ~pend_q) == '0)); // R3
  AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (($past(en_set & ~en_clr) & ~en_q) == '0)); // R4

endmodule

// File: rtl/irq_elig_calc.sv
module irq_elig_calc
  import irq_bank_pkg::*;
#(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] pend_q,
  input  logic [NLINES-1:0] lvl_q,
  input  logic [NLINES-1:0] en_q,
  input  logic [NLINES-1:0] act_q,
  input  logic [NLINES-1:0] edge_q,
  input  logic [NLINES-1:0] grp_q,
  input  logic [NLINES-1:0] gmod_q,
  input  irq_ctl_t          ctl,
  output logic [NLINES-1:0] eligible,
  output logic              any_eligible
);

  // latched pending merged with live level of level-triggered lines
  function automatic logic [NLINES-1:0] pending_of(input logic [NLINES-1:0] latch,
                                                   input logic [NLINES-1:0] trig,
                                                   input logic [NLINES-1:0] lvl);
    return latch | (~trig & lvl);
  endfunction

  // per-line pass mask from group class and control flags
  function automatic logic [NLINES-1:0] class_pass(input logic [NLINES-1:0] grp,
                                                   input logic [NLINES-1:0] gmod,
                                                   input irq_ctl_t          c);
    logic [NLINES-1:0] gm;
    gm = c.sec_off ? '0 : gmod;
    return ({NLINES{c.en_g1ns}} & grp)
         | ({NLINES{c.en_g1s}}  & ~grp & gm)
         | ({NLINES{c.en_g0}}   & ~grp & ~gm);
  endfunction

  logic [NLINES-1:0] pend_w;
  logic [NLINES-1:0] pass_w;
  logic [NLINES-1:0] elig_d;

  assign pend_w = pending_of(pend_q, edge_q, lvl_q);
  assign pass_w = class_pass(grp_q, gmod_q, ctl);
  assign elig_d = pend_w & en_q & ~act_q & pass_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eligible     <= '0;
      any_eligible <= 1'b0;
    end else begin
      eligible     <= elig_d;
      any_eligible <= |elig_d;
    end
  end

  AST_INACTIVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((eligible & $past(act_q | ~en_q)) == '0)); // R5
  AST_G1NS_GATED: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((eligible & $past(grp_q & {NLINES{~ctl.en_g1ns}})) == '0)); // R7
  AST_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((eligible & ~$past(pend_q | lvl_q)) == '0)); // R2

endmodule

// File: rtl/irq_elig_bank.sv
module irq_elig_bank
  import irq_bank_pkg::*;
#(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] line_in,
  input  logic [NLINES-1:0] pend_set,
  input  logic [NLINES-1:0] pend_clr,
  input  logic [NLINES-1:0] en_set,
  input  logic [NLINES-1:0] en_clr,
  input  logic [NLINES-1:0] act_set,
  input  logic [NLINES-1:0] act_clr,
  input  logic              cfg_we,
  input  logic [NLINES-1:0] cfg_edge,
  input  logic [NLINES-1:0] cfg_grp,
  input  logic [NLINES-1:0] cfg_gmod,
  input  logic              ctl_sec_off,
  input  logic              ctl_en_g0,
  input  logic              ctl_en_g1s,
  input  logic              ctl_en_g1ns,
  output logic [NLINES-1:0] eligible,
  output logic              any_eligible
);

  logic [NLINES-1:0] lvl_w, rise_w;
  logic [NLINES-1:0] pend_w, en_w, act_w, edge_w, grp_w, gmod_w;
  irq_ctl_t          ctl_w;

  assign ctl_w = '{sec_off: ctl_sec_off, en_g0: ctl_en_g0,
                   en_g1s: ctl_en_g1s, en_g1ns: ctl_en_g1ns};

  irq_line_sampler #(.NLINES(NLINES)) u_samp (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .lvl_q(lvl_w), .rise_w(rise_w)
  );

  irq_state_regs #(.NLINES(NLINES)) u_state (
    .clk(clk), .rst_n(rst_n), .rise(rise_w),
    .pend_set(pend_set), .pend_clr(pend_clr),
    .en_set(en_set), .en_clr(en_clr),
    .act_set(act_set), .act_clr(act_clr),
    .cfg_we(cfg_we), .cfg_edge(cfg_edge), .cfg_grp(cfg_grp), .cfg_gmod(cfg_gmod),
    .pend_q(pend_w), .en_q(en_w), .act_q(act_w),
    .edge_q(edge_w), .grp_q(grp_w), .gmod_q(gmod_w)
  );

  irq_elig_calc #(.NLINES(NLINES)) u_calc (
    .clk(clk), .rst_n(rst_n),
    .pend_q(pend_w), .lvl_q(lvl_w), .en_q(en_w), .act_q(act_w),
    .edge_q(edge_w), .grp_q(grp_w), .gmod_q(gmod_w), .ctl(ctl_w),
    .eligible(eligible), .any_eligible(any_eligible)
  );

  AST_ANY_MATCH: assert property (@(posedge clk) disable iff (!rst_n) any_eligible == (|eligible)); // R11
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> (eligible == '0 && !any_eligible)); // R1

endmodule

// File: tb/irq_elig_bank_tb.sv
module irq_elig_bank_tb;

  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] line_in = '0, pend_set = '0, pend_clr = '0;
  logic [N-1:0] en_set = '0, en_clr = '0, act_set = '0, act_clr = '0;
  logic         cfg_we = 1'b0;
  logic [N-1:0] cfg_edge = '0, cfg_grp = '0, cfg_gmod = '0;
  logic         ctl_sec_off = 1'b0, ctl_en_g0 = 1'b0, ctl_en_g1s = 1'b0, ctl_en_g1ns = 1'b0;
  logic [N-1:0] eligible;
  logic         any_eligible;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;  // 125 MHz

  irq_elig_bank #(.NLINES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .pend_set(pend_set), .pend_clr(pend_clr),
    .en_set(en_set), .en_clr(en_clr), .act_set(act_set), .act_clr(act_clr),
    .cfg_we(cfg_we), .cfg_edge(cfg_edge), .cfg_grp(cfg_grp), .cfg_gmod(cfg_gmod),
    .ctl_sec_off(ctl_sec_off), .ctl_en_g0(ctl_en_g0),
    .ctl_en_g1s(ctl_en_g1s), .ctl_en_g1ns(ctl_en_g1ns),
    .eligible(eligible), .any_eligible(any_eligible)
  );

  // ---------------- behavioural reference model ----------------
  bit [N-1:0] m_pend, m_en, m_act, m_trig, m_grp, m_gmod, m_lvl;
  bit [N-1:0] exp_elig;
  bit         exp_any;
  bit         model_live = 1'b0;

  // line-by-line eligibility, classified with explicit branches
  function automatic bit [N-1:0] model_elig();
    bit [N-1:0] r = '0;
    for (int i = 0; i < N; i++) begin
      bit pend, ok, mod;
      pend = m_pend[i] || (!m_trig[i] && m_lvl[i]);
      mod  = ctl_sec_off ? 1'b0 : m_gmod[i];
      if (m_grp[i])  ok = ctl_en_g1ns;      // R7
      else if (mod)  ok = ctl_en_g1s;       // R8, R6
      else           ok = ctl_en_g0;        // R9
      r[i] = pend && m_en[i] && !m_act[i] && ok;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_en = '0; m_act = '0; m_trig = '0;
      m_grp = '0; m_gmod = '0; m_lvl = '0;
      exp_elig = '0; exp_any = 1'b0; model_live = 1'b0;
    end else begin
      exp_elig = model_elig();
      exp_any = 0;
      for (int i = 0; i < N; i++) if (exp_elig[i]) exp_any = 1;
      for (int i = 0; i < N; i++) begin
        bit hit;
        hit = m_trig[i] && line_in[i] && !m_lvl[i];
        if (pend_clr[i]) m_pend[i] = 0; else if (pend_set[i] || hit) m_pend[i] = 1;
        if (en_clr[i])   m_en[i] = 0;   else if (en_set[i])  m_en[i] = 1;
        if (act_clr[i])  m_act[i] = 0;  else if (act_set[i]) m_act[i] = 1;
      end
      m_lvl = line_in;
      if (cfg_we) begin m_trig = cfg_edge; m_grp = cfg_grp; m_gmod = cfg_gmod; end
      model_live = 1'b1;
    end
  end

  // cycle compare, away from the active edge (R10, R11)
  always @(negedge clk) begin
    if (model_live && !done) begin
      compared++;
      if (eligible !== exp_elig) begin
        mismatched++;
        $display("FAIL R10 (%s) eligible act=%h exp=%h t=%0t", cur_req, eligible, exp_elig, $time);
      end
      compared++;
      if (any_eligible !== exp_any) begin
        mismatched++;
        $display("FAIL R11 any_eligible act=%b exp=%b t=%0t", any_eligible, exp_any, $time);
      end
    end
  end

  // directed check against a hand-computed value
  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_strobes();
    pend_set = '0; pend_clr = '0; en_set = '0; en_clr = '0;
    act_set = '0; act_clr = '0; cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    mismatched++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    step(3);
    chk("R1 reset eligible", eligible, '0);
    chk("R1 reset any", {31'd0, any_eligible}, '0);
    rst_n = 1'b1;
    step(1);

    // R1/R2: default level trigger, level input drives pending
    cur_req = "R2";
    ctl_en_g0 = 1'b1;
    en_set = '1; step(1); clear_strobes();
    line_in = 32'h0000_0008;
    step(3);
    chk("R2 level line high", eligible, 32'h0000_0008);
    chk("R11 any high", {31'd0, any_eligible}, 32'd1);
    line_in = '0;
    step(3);
    chk("R2 level line dropped", eligible, '0);

    // R12/R3: make line 20 edge-triggered
    cur_req = "R3";
    cfg_we = 1'b1; cfg_edge = 32'h0010_0000; cfg_grp = '0; cfg_gmod = '0;
    step(1); clear_strobes();
    line_in = 32'h0010_0000;
    step(3);
    chk("R3 edge latched", eligible, 32'h0010_0000);
    pend_clr = 32'h0010_0000; step(1); clear_strobes();
    step(3);
    chk("R3 held high no retrigger", eligible, '0);
    line_in = '0; step(2);
    line_in = 32'h0010_0000; step(3);
    chk("R3 second edge latched", eligible, 32'h0010_0000);
    // R4: edge and clear together, clear wins
    line_in = '0; pend_clr = 32'h0010_0000; step(1); clear_strobes();
    line_in = 32'h0010_0000; pend_clr = 32'h0010_0000; step(1); clear_strobes();
    step(3);
    chk("R4 clear beats edge", eligible, '0);

    // R4: set and clear together on line 7
    cur_req = "R4";
    pend_set = 32'h80; pend_clr = 32'h80; step(1); clear_strobes();
    step(3);
    chk("R4 pend clear wins", eligible, '0);
    pend_set = 32'h80; step(1); clear_strobes(); step(3);
    chk("R4 pend set", eligible, 32'h80);

    // R5: enable and active gating
    cur_req = "R5";
    en_clr = 32'h80; step(1); clear_strobes(); step(3);
    chk("R5 disabled", eligible, '0);
    en_set = 32'h80; step(1); clear_strobes(); step(3);
    chk("R5 re-enabled", eligible, 32'h80);
    act_set = 32'h80; step(1); clear_strobes(); step(3);
    chk("R5 active blocks", eligible, '0);
    act_set = 32'h80; act_clr = 32'h80; step(1); clear_strobes(); step(3);
    chk("R4 active clear wins", eligible, 32'h80);

    // R6..R9: class decode across all control combinations
    cur_req = "R8";
    line_in = '0; pend_clr = '1; step(1); clear_strobes();
    cfg_we = 1'b1; cfg_edge = '0; cfg_grp = 32'h2; cfg_gmod = 32'h6;
    pend_set = 32'hE; step(1); clear_strobes();
    for (int c = 0; c < 16; c++) begin
      logic [N-1:0] want;
      {ctl_sec_off, ctl_en_g0, ctl_en_g1s, ctl_en_g1ns} = 4'(c);
      step(2);
      want = '0;
      if (ctl_en_g1ns) want[1] = 1'b1;                          // R7
      if (ctl_sec_off ? ctl_en_g0 : ctl_en_g1s) want[2] = 1'b1; // R6, R8
      if (ctl_en_g0) want[3] = 1'b1;                            // R9
      chk(ctl_sec_off ? "R6 class sweep" : "R9 class sweep", eligible, want);
    end

    // R10: random traffic against the model
    cur_req = "R10";
    for (int k = 0; k < 600; k++) begin
      line_in  = $urandom;
      pend_set = $urandom & $urandom & $urandom;
      pend_clr = $urandom & $urandom & $urandom;
      en_set   = $urandom & $urandom;
      en_clr   = $urandom & $urandom & $urandom;
      act_set  = $urandom & $urandom & $urandom;
      act_clr  = $urandom & $urandom;
      cfg_we   = (($urandom & 15) == 0);
      cfg_edge = $urandom; cfg_grp = $urandom; cfg_gmod = $urandom;
      {ctl_sec_off, ctl_en_g0, ctl_en_g1s, ctl_en_g1ns} = 4'($urandom);
      step(1);
    end
    clear_strobes();
    step(3);

    // R1: reset in the middle of activity clears everything
    cur_req = "R1";
    rst_n = 1'b0; step(2);
    chk("R1 mid reset", eligible, '0);
    rst_n = 1'b1; line_in = 32'h1; ctl_en_g0 = 1'b1; ctl_sec_off = 1'b0;
    en_set = 32'h1; step(1); clear_strobes(); step(3);
    chk("R1 level type after reset", eligible, 32'h1);
    finish_run();
  end

endmodule